// File: doc/BRIEF.md
# Diagonal Tile-Order Address Generator

This block drives an out-of-place tiled matrix transpose. The matrix is cut into square tiles of `TILE` x `TILE` elements, and the block walks every tile once. The walk does not follow plain raster order. A linear tile issue counter is remapped to diagonal coordinates. Under that remapping, the tiles that are in flight at the same time write to destination rows that fall in different memory partitions, not stacked in one. The block does not move any data. For every beat it gives the element address to read in the source matrix, the element address to write in the destination matrix, and the partition index of that write.

A consumer loads the matrix size in tiles and pulses `start`. The generator then presents one beat at a time under a valid/ready handshake. Inside a tile, the column index changes fastest. Rows are covered by `LANES` row groups, and each group steps `TILE/LANES` times by `LANES` rows. After the last beat is accepted, a one-cycle `done` pulse closes the run.

Top module: `diag_tile_addr_gen`

## Requirements
- R1: After reset `valid` and `done` are both 0.
- R2: A `start` pulse seen while idle, with nonzero `grid_w` and `grid_h`, latches both sizes. From the next cycle `valid` is 1 and the first beat belongs to tile row 0, column 0.
- R3: When `grid_w == grid_h`, the tile with issue index b (b = 0, 1, ...) has source tile row `b mod grid_w` and source tile column `((b mod grid_w) + b / grid_w) mod grid_w`.
- R4: When `grid_w != grid_h`, the tile with issue index b has source tile row `r = b mod grid_h` and source tile column `(b / grid_h + r) mod grid_w`.
- R5: Every tile coordinate pair of the grid is issued exactly once. A run is exactly `grid_w*grid_h*TILE*TILE` accepted beats.
- R6: Within a tile, beat k (0 .. TILE*TILE-1) has column offset `k mod TILE` and row offset `lane + LANES*step`. Here `lane` is the row group and `step` is the group's step count, with lanes cycling before steps, which gives row offset `k / TILE`.
- R7: `src_addr` = (source tile column*TILE + column offset) + (source tile row*TILE + row offset) * grid_w*TILE, counted in elements.
- R8: `dst_addr` = (source tile row*TILE + column offset) + (source tile column*TILE + row offset) * grid_h*TILE. The destination tile coordinate ports carry the source coordinates swapped.
- R9: `dst_part` = floor(`dst_addr`*ELEM_BYTES / PART_BYTES) mod NUM_PARTS. With the defaults (4-byte elements, 256-byte partitions, 8 partitions) this is `dst_addr` bits 8:6.
- R10: While `valid` is 1 and `ready` is 0, every beat output stays unchanged on the next cycle.
- R11: `done` is a one-cycle pulse in the cycle after the final beat is accepted, and `valid` is 0 in that cycle.
- R12: A `start` pulse during a run has no effect. The run keeps its latched sizes and sequence.
- R13: A `start` pulse with `grid_w` or `grid_h` equal to 0 is ignored. `valid` stays 0 and no `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (honoured only while idle) |
| grid_w | input | GRID_BITS | Matrix width in tiles |
| grid_h | input | GRID_BITS | Matrix height in tiles |
| ready | input | 1 | Consumer accepts the current beat |
| valid | output | 1 | A beat is presented |
| src_tile_row | output | GRID_BITS | Source tile row of the current beat |
| src_tile_col | output | GRID_BITS | Source tile column of the current beat |
| dst_tile_row | output | GRID_BITS | Destination tile row (equals source column) |
| dst_tile_col | output | GRID_BITS | Destination tile column (equals source row) |
| src_addr | output | 2*(GRID_BITS+log2 TILE) | Source element address |
| dst_addr | output | 2*(GRID_BITS+log2 TILE) | Destination element address |
| dst_part | output | log2 NUM_PARTS | Memory partition of the destination address |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
A `start` sampled at a clock edge gives `valid` and the first beat in the very next cycle. Every accepted beat, meaning `valid` and `ready` both high at an edge, updates the beat outputs one cycle later. `done` follows one cycle after the last handshake. The bench drives `start`, the sizes and `ready` on the falling edge. It reads the outputs at the next falling edge, after the rising edge that used them. A beat therefore counts as accepted exactly when the sample shows `valid` and the bench has `ready` high. The `done` and idle checks are placed one and two falling edges after the final acceptance.

// File: rtl/diag_tile_pkg.sv
package diag_tile_pkg;

    localparam int DEF_TILE       = 32;
    localparam int DEF_LANES      = 8;
    localparam int DEF_GRID_BITS  = 6;
    localparam int DEF_ELEM_BYTES = 4;
    localparam int DEF_PART_BYTES = 256;
    localparam int DEF_NUM_PARTS  = 8;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_t;

endpackage

// File: rtl/diag_tile_walker.sv
module diag_tile_walker #(
    parameter int GRID_BITS = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic                 adv,
    input  logic [GRID_BITS-1:0] gw,
    input  logic [GRID_BITS-1:0] gh,
    output logic [GRID_BITS-1:0] tile_row,
    output logic [GRID_BITS-1:0] tile_col,
    output logic                 last_tile
);
    // rem = issue index mod gh, quo = issue index / gh, col tracks (quo + rem) mod gw.
    // For a square grid gw == gh, so this reduces to the square-grid diagonal mapping.
    logic [GRID_BITS-1:0] rem_q, quo_q, col_q;
    logic [GRID_BITS-1:0] quo_inc, col_inc;
    logic                 rem_wrap;

    assign rem_wrap = (rem_q == gh - GRID_BITS'(1));
    assign quo_inc  = quo_q + GRID_BITS'(1);
    assign col_inc  = col_q + GRID_BITS'(1);

    always_ff @(posedge clk) begin
        if (rst || load) begin
            rem_q <= '0;
            quo_q <= '0;
            col_q <= '0;
        end else if (adv) begin
            if (rem_wrap) begin
                rem_q <= '0;
                quo_q <= quo_inc;
                col_q <= (quo_inc == gw) ? '0 : quo_inc;
            end else begin
                rem_q <= rem_q + GRID_BITS'(1);
                col_q <= (col_inc == gw) ? '0 : col_inc;
            end
        end
    end

    assign tile_row  = rem_q;
    assign tile_col  = col_q;
    assign last_tile = rem_wrap && (quo_q == gw - GRID_BITS'(1));

    AST_ROW_STEP: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && !rem_wrap) |=> (rem_q == $past(rem_q) + GRID_BITS'(1))); // R4

    AST_ROW_WRAP: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && rem_wrap) |=> (rem_q == '0 && col_q == (($past(quo_q) + GRID_BITS'(1) == gw) ? '0 : $past(quo_q) + GRID_BITS'(1)))); // R3

endmodule

// File: rtl/diag_beat_seq.sv
module diag_beat_seq #(
    parameter int TILE  = 32,
    parameter int LANES = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load,
    input  logic                     adv,
    output logic [$clog2(TILE)-1:0]  col_off,
    output logic [$clog2(TILE)-1:0]  row_off,
    output logic                     last_beat
);
    localparam int TB    = $clog2(TILE);
    localparam int STEPS = TILE / LANES;
    localparam int LB    = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int SB    = (STEPS > 1) ? $clog2(STEPS) : 1;

    logic [TB-1:0] col_q;
    logic [LB-1:0] lane_q;
    logic [SB-1:0] step_q;
    logic          col_end, lane_end, step_end;

    assign col_end  = (col_q  == TB'(TILE - 1));
    assign lane_end = (lane_q == LB'(LANES - 1));
    assign step_end = (step_q == SB'(STEPS - 1));

    always_ff @(posedge clk) begin
        if (rst || load) begin
            col_q  <= '0;
            lane_q <= '0;
            step_q <= '0;
        end else if (adv) begin
            col_q <= col_end ? '0 : col_q + TB'(1);
            if (col_end) begin
                lane_q <= lane_end ? '0 : lane_q + LB'(1);
                if (lane_end)
                    step_q <= step_end ? '0 : step_q + SB'(1);
            end
        end
    end

    assign col_off   = col_q;
    assign row_off   = TB'(int'(step_q) * LANES + int'(lane_q));
    assign last_beat = col_end && lane_end && step_end;

    AST_COL_WRAP: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && col_end) |=> (col_off == '0)); // R6

    AST_ROW_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && col_end && !last_beat) |=> (row_off == $past(row_off) + TB'(1))); // R6

endmodule

// File: rtl/diag_addr_calc.sv
module diag_addr_calc #(
    parameter int GRID_BITS  = 6,
    parameter int TILE       = 32,
    parameter int ELEM_BYTES = 4,
    parameter int PART_BYTES = 256,
    parameter int NUM_PARTS  = 8
) (
    input  logic [GRID_BITS-1:0]                       gw,
    input  logic [GRID_BITS-1:0]                       gh,
    input  logic [GRID_BITS-1:0]                       tile_row,
    input  logic [GRID_BITS-1:0]                       tile_col,
    input  logic [$clog2(TILE)-1:0]                    col_off,
    input  logic [$clog2(TILE)-1:0]                    row_off,
    output logic [2*(GRID_BITS+$clog2(TILE))-1:0]      src_addr,
    output logic [2*(GRID_BITS+$clog2(TILE))-1:0]      dst_addr,
    output logic [$clog2(NUM_PARTS)-1:0]               dst_part
);
    localparam int TB         = $clog2(TILE);
    localparam int COORD_W    = GRID_BITS + TB;
    localparam int ADDR_W     = 2 * COORD_W;
    localparam int PART_SHIFT = $clog2(PART_BYTES / ELEM_BYTES);
    localparam int PART_BITS  = $clog2(NUM_PARTS);

    // Tile sizes are powers of two, so tile*TILE + offset is a concatenation.
    logic [ADDR_W-1:0] src_x, src_y, dst_x, dst_y, src_stride, dst_stride;

    always_comb begin
        src_x      = ADDR_W'({tile_col, col_off});
        src_y      = ADDR_W'({tile_row, row_off});
        dst_x      = ADDR_W'({tile_row, col_off});
        dst_y      = ADDR_W'({tile_col, row_off});
        src_stride = ADDR_W'({gw, TB'(0)});
        dst_stride = ADDR_W'({gh, TB'(0)});
        src_addr   = src_x + src_y * src_stride;
        dst_addr   = dst_x + dst_y * dst_stride;
        dst_part   = dst_addr[PART_SHIFT +: PART_BITS];
    end

endmodule

// File: rtl/diag_tile_addr_gen.sv
module diag_tile_addr_gen
    import diag_tile_pkg::*;
#(
    parameter int GRID_BITS  = DEF_GRID_BITS,
    parameter int TILE       = DEF_TILE,
    parameter int LANES      = DEF_LANES,
    parameter int ELEM_BYTES = DEF_ELEM_BYTES,
    parameter int PART_BYTES = DEF_PART_BYTES,
    parameter int NUM_PARTS  = DEF_NUM_PARTS
) (
    input  logic                                       clk,
    input  logic                                       rst,
    input  logic                                       start,
    input  logic [GRID_BITS-1:0]                       grid_w,
    input  logic [GRID_BITS-1:0]                       grid_h,
    input  logic                                       ready,
    output logic                                       valid,
    output logic [GRID_BITS-1:0]                       src_tile_row,
    output logic [GRID_BITS-1:0]                       src_tile_col,
    output logic [GRID_BITS-1:0]                       dst_tile_row,
    output logic [GRID_BITS-1:0]                       dst_tile_col,
    output logic [2*(GRID_BITS+$clog2(TILE))-1:0]      src_addr,
    output logic [2*(GRID_BITS+$clog2(TILE))-1:0]      dst_addr,
    output logic [$clog2(NUM_PARTS)-1:0]               dst_part,
    output logic                                       done
);
    localparam int TB = $clog2(TILE);

    run_state_t           state_q;
    logic [GRID_BITS-1:0] gw_q, gh_q;
    logic                 done_q;
    logic                 accept, fire, finish;
    logic                 last_beat, last_tile;
    logic [TB-1:0]        col_off, row_off;

    assign accept = start && (state_q == ST_IDLE) && (grid_w != '0) && (grid_h != '0);
    assign valid  = (state_q == ST_RUN);
    assign fire   = valid && ready;
    assign finish = fire && last_beat && last_tile;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            gw_q    <= '0;
            gh_q    <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= finish;
            if (accept) begin
                state_q <= ST_RUN;
                gw_q    <= grid_w;
                gh_q    <= grid_h;
            end else if (finish) begin
                state_q <= ST_IDLE;
            end
        end
    end

    assign done = done_q;

    diag_tile_walker #(.GRID_BITS(GRID_BITS)) u_walker (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .adv       (fire && last_beat),
        .gw        (gw_q),
        .gh        (gh_q),
        .tile_row  (src_tile_row),
        .tile_col  (src_tile_col),
        .last_tile (last_tile)
    );

    diag_beat_seq #(.TILE(TILE), .LANES(LANES)) u_beats (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .adv       (fire),
        .col_off   (col_off),
        .row_off   (row_off),
        .last_beat (last_beat)
    );

    diag_addr_calc #(
        .GRID_BITS  (GRID_BITS),
        .TILE       (TILE),
        .ELEM_BYTES (ELEM_BYTES),
        .PART_BYTES (PART_BYTES),
        .NUM_PARTS  (NUM_PARTS)
    ) u_addr (
        .gw       (gw_q),
        .gh       (gh_q),
        .tile_row (src_tile_row),
        .tile_col (src_tile_col),
        .col_off  (col_off),
        .row_off  (row_off),
        .src_addr (src_addr),
        .dst_addr (dst_addr),
        .dst_part (dst_part)
    );

    assign dst_tile_row = src_tile_col;
    assign dst_tile_col = src_tile_row;

    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> (valid && $stable(src_addr) && $stable(dst_addr) && $stable(src_tile_row) && $stable(src_tile_col))); // R10

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R11

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !valid); // R11

    AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
        (valid && start && !finish) |=> (valid && $stable(gw_q) && $stable(gh_q))); // R12

    AST_TILE_RANGE: assert property (@(posedge clk) disable iff (rst)
        valid |-> (src_tile_row < gh_q && src_tile_col < gw_q)); // R5

    AST_ZERO_DIM: assert property (@(posedge clk) disable iff (rst)
        (!valid && start && (grid_w == '0 || grid_h == '0)) |=> !valid); // R13

endmodule

// File: tb/diag_tile_addr_gen_test.sv
`timescale 1ns/1ps
module diag_tile_addr_gen_test;

    localparam int GB = 6;
    localparam int T  = 32;
    localparam int AW = 2 * (GB + 5);

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [GB-1:0] grid_w, grid_h;
    logic          ready;
    logic          valid, done;
    logic [GB-1:0] src_tile_row, src_tile_col, dst_tile_row, dst_tile_col;
    logic [AW-1:0] src_addr, dst_addr;
    logic [2:0]    dst_part;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    diag_tile_addr_gen uut (
        .clk(clk), .rst(rst), .start(start), .grid_w(grid_w), .grid_h(grid_h),
        .ready(ready), .valid(valid), .src_tile_row(src_tile_row),
        .src_tile_col(src_tile_col), .dst_tile_row(dst_tile_row),
        .dst_tile_col(dst_tile_col), .src_addr(src_addr), .dst_addr(dst_addr),
        .dst_part(dst_part), .done(done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    task automatic test_reset();
        rst = 1; start = 0; ready = 0; grid_w = '0; grid_h = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(valid === 1'b0, "R1", "valid after reset", longint'(valid), 0);
        check(done === 1'b0, "R1", "done after reset", longint'(done), 0);
    endtask

    task automatic test_zero_dim();
        @(negedge clk);
        grid_w = 6'd0; grid_h = 6'd2; start = 1;
        @(negedge clk);
        start = 0;
        check(valid === 1'b0, "R13", "valid after zero-width start", longint'(valid), 0);
        @(negedge clk);
        check(done === 1'b0, "R13", "done after zero-width start", longint'(done), 0);
    endtask

    // Full run with expected values from the requirement formulas.
    task automatic run_grid(input int gw, input int gh, input bit stall, input bit poke);
        int total, beat, cyc, ntiles;
        int coord_bad, src_bad, dst_bad, part_bad, hold_bad, dup_bad;
        bit seen [64];
        bit prev_stall;
        logic [AW-1:0] h_src, h_dst;
        logic [GB-1:0] h_r, h_c;
        string mreq;
        mreq = (gw == gh) ? "R3" : "R4";
        coord_bad = 0; src_bad = 0; dst_bad = 0; part_bad = 0;
        hold_bad = 0; dup_bad = 0; ntiles = 0;
        foreach (seen[i]) seen[i] = 0;
        @(negedge clk);
        grid_w = GB'(gw); grid_h = GB'(gh); start = 1; ready = 0;
        @(negedge clk);
        start = 0;
        check(valid === 1'b1 && src_tile_row == 0 && src_tile_col == 0, "R2",
              "first beat valid/row/col", {valid, src_tile_row, src_tile_col}, {1'b1, 12'd0});
        total = gw * gh * T * T;
        beat = 0; cyc = 0; prev_stall = 0;
        h_src = '0; h_dst = '0; h_r = '0; h_c = '0;
        while (beat < total && cyc < 60000) begin
            ready = !(stall && (cyc % 4 >= 2));
            start = poke && (beat == 1500);
            grid_w = start ? GB'(1) : GB'(gw);
            grid_h = start ? GB'(1) : GB'(gh);
            if (prev_stall && (valid !== 1'b1 || src_addr !== h_src || dst_addr !== h_dst ||
                               src_tile_row !== h_r || src_tile_col !== h_c))
                hold_bad++;
            if (valid && ready) begin
                int t, e, er, ec, cx, ry, es, ed;
                t = beat / (T * T);
                e = beat % (T * T);
                if (gw == gh) begin
                    er = t % gw;
                    ec = ((t % gw) + t / gw) % gw;
                end else begin
                    er = t % gh;
                    ec = (t / gh + er) % gw;
                end
                cx = e % T;
                ry = e / T;
                es = (ec * T + cx) + (er * T + ry) * gw * T;
                ed = (er * T + cx) + (ec * T + ry) * gh * T;
                if (int'(src_tile_row) != er || int'(src_tile_col) != ec) coord_bad++;
                if (e == 0) begin
                    if (seen[er * 8 + ec]) dup_bad++;
                    seen[er * 8 + ec] = 1;
                    ntiles++;
                end
                if (int'(src_addr) != es) src_bad++;
                if (int'(dst_addr) != ed || int'(dst_tile_row) != ec || int'(dst_tile_col) != er)
                    dst_bad++;
                if (int'(dst_part) != ((ed * 4) / 256) % 8) part_bad++;
                beat++;
            end
            prev_stall = valid && !ready;
            h_src = src_addr; h_dst = dst_addr; h_r = src_tile_row; h_c = src_tile_col;
            cyc++;
            @(negedge clk);
        end
        start = 0; ready = 0; grid_w = GB'(gw); grid_h = GB'(gh);
        check(coord_bad == 0, mreq, "tile coordinate mismatches", coord_bad, 0);
        check(dup_bad == 0 && ntiles == gw * gh && beat == total, "R5",
              "distinct tiles issued", ntiles - dup_bad, gw * gh);
        check(src_bad == 0, "R7", "source address mismatches (R6 order)", src_bad, 0);
        check(dst_bad == 0, "R8", "destination address mismatches (R6 order)", dst_bad, 0);
        check(part_bad == 0, "R9", "partition index mismatches", part_bad, 0);
        if (stall)
            check(hold_bad == 0, "R10", "outputs moved during stall", hold_bad, 0);
        if (poke)
            check(beat == total && coord_bad == 0, "R12", "beats after mid-run start", beat, total);
        check(done === 1'b1 && valid === 1'b0, "R11", "done/valid after last beat",
              {done, valid}, 2'b10);
        @(negedge clk);
        check(done === 1'b0, "R11", "done one cycle only", longint'(done), 0);
    endtask

    initial begin
        test_reset();
        test_zero_dim();
        run_grid(2, 2, 1'b0, 1'b0);
        run_grid(3, 2, 1'b1, 1'b1);
        run_grid(2, 3, 1'b0, 1'b0);
        run_grid(3, 3, 1'b0, 1'b0);
        run_grid(1, 1, 1'b1, 1'b0);
        report();
    end

endmodule